// File: doc/BRIEF.md
# SMM and Stop-Clock Event Sequencer

This block is the small state machine in a simple processor core that decides which execution state the core is in: Run, Halt, Stop Grant or system management mode (SMM). It arbitrates three kinds of event:

- stop-clock requests;
- system management interrupts, optionally marked as coming from a trapped I/O instruction;
- debug breakpoint traps.

All outputs are registered. Each input is sampled on a rising edge, and the result is visible in the cycle that follows.

When a debug trap collides with an SMI from a trapped I/O instruction, the SMI wins and the trap is held pending through SMM. On return from SMM, the pending trap is delivered as a single debug-frame-write pulse, unless the I/O restart flag read from the save area is set. In that case the trap is dropped, because re-executing the I/O instruction raises it again. The block also pulses strobes that save the DR6/DR7 debug registers when SMM is entered and restore them when SMM is left.

Top module: `smm_stopclk_seq`

## Requirements
- R1: After reset, `state_o` is RUN (2'd0), and `stop_ack`, `smm_enter`, `dbg_frame`, `dr_save` and `dr_restore` are all low.
- R2: Stop-clock request from Run:
  - In RUN, a high `stop_req` moves `state_o` to STOPGNT (2'd2) in the next cycle.
  - `stop_ack` is high for exactly that one cycle.
- R3: Stop-clock request from Halt and the return path:
  - A high `stop_req` is honoured in HALT (2'd1) as well as in RUN.
  - When `stop_req` falls in STOPGNT, `state_o` returns to the state Stop Grant was entered from.
- R4: If `stop_req` rises again in the first cycle after Stop Grant is left, Stop Grant is re-entered at once with a fresh one-cycle `stop_ack`. No retire cycle is guaranteed in between.
- R5: SMM entry:
  - An SMI (`smi_req`) in RUN or HALT moves `state_o` to SMM (2'd3).
  - `smm_enter` and `dr_save` are high together for exactly that one cycle.
- R6: SMM exit:
  - `rsm_stb` in SMM moves `state_o` to RUN with a one-cycle `dr_restore`.
  - `rsm_stb` in any other state changes nothing and gives no `dr_restore`.
- R7: Deferred debug trap, delivered:
  - `smi_req` with `smi_io`=1 and `dbg_req` in the same cycle enters SMM with no `dbg_frame`.
  - After RSM with `io_restart`=0, one `dbg_frame` pulse appears in the cycle after `state_o` first shows RUN.
- R8: Deferred debug trap, cancelled: if `io_restart`=1 when RSM is taken, the pending trap is dropped and no `dbg_frame` follows.
- R9: Debug trap with a non-I/O SMI (`smi_io`=0) in the same cycle:
  - The trap is not deferred. `dbg_frame` pulses while `state_o` is still RUN, and SMM is entered in the next cycle.
  - No `dbg_frame` follows the RSM.
- R10: Debug trap alone:
  - A `dbg_req` alone in RUN or HALT gives a one-cycle `dbg_frame` in the next cycle and leaves `state_o` unchanged.
  - `dbg_req` is ignored in STOPGNT and in SMM.
- R11: SMI during Stop Grant:
  - An SMI that arrives in STOPGNT does not leave Stop Grant.
  - It is held and taken (entry to SMM) on the first cycle after Stop Grant is left.
- R12: A `halt_stb` in RUN with no other request moves `state_o` to HALT.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| stop_req | input | 1 | Stop-clock request (level) |
| smi_req | input | 1 | System management interrupt request (pulse) |
| smi_io | input | 1 | SMI qualifier: raised by a trapped I/O instruction |
| dbg_req | input | 1 | Debug breakpoint trap request (pulse) |
| halt_stb | input | 1 | Halt instruction retired (pulse) |
| rsm_stb | input | 1 | Resume-from-SMM instruction (pulse) |
| io_restart | input | 1 | I/O restart flag from the save area, valid with `rsm_stb` |
| state_o | output | 2 | Current state: 0 RUN, 1 HALT, 2 STOPGNT, 3 SMM |
| stop_ack | output | 1 | One-cycle stop-grant acknowledge |
| smm_enter | output | 1 | One-cycle SMM entry strobe |
| dbg_frame | output | 1 | One-cycle debug fault-frame write strobe |
| dr_save | output | 1 | One-cycle DR6/DR7 save strobe |
| dr_restore | output | 1 | One-cycle DR6/DR7 restore strobe |

## Verification
The assertions assume the following about the inputs:
- `smi_req`, `dbg_req`, `halt_stb` and `rsm_stb` are single-cycle pulses.
- `stop_req` is a level that is held until Stop Grant is reached.
- `io_restart` only matters in the cycle `rsm_stb` is high.

The directed tasks raise each strobe for exactly one cycle and drop it before the next edge. They hold `stop_req` across the whole stop window and present `io_restart` together with `rsm_stb`. No task issues `rsm_stb` while the core is in Stop Grant, which leaves the SMM-only properties free of stimulus that the core could never produce.

// File: rtl/smm_stopclk_seq.sv
module smm_stopclk_seq (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       stop_req,
  input  logic       smi_req,
  input  logic       smi_io,
  input  logic       dbg_req,
  input  logic       halt_stb,
  input  logic       rsm_stb,
  input  logic       io_restart,
  output logic [1:0] state_o,
  output logic       stop_ack,
  output logic       smm_enter,
  output logic       dbg_frame,
  output logic       dr_save,
  output logic       dr_restore
);

  localparam logic [1:0] S_RUN  = 2'd0;
  localparam logic [1:0] S_HALT = 2'd1;
  localparam logic [1:0] S_STOP = 2'd2;
  localparam logic [1:0] S_SMM  = 2'd3;

  logic [1:0] st;
  logic       ret_halt;
  logic       dbg_pend;
  logic       smi_pend;
  logic       pend_io;

  wire smi_now = smi_req | smi_pend;
  wire io_now  = smi_req ? smi_io : pend_io;
  wire deliver = (st == S_RUN) && dbg_pend;

  assign state_o = st;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st         <= S_RUN;
      ret_halt   <= 1'b0;
      dbg_pend   <= 1'b0;
      smi_pend   <= 1'b0;
      pend_io    <= 1'b0;
      stop_ack   <= 1'b0;
      smm_enter  <= 1'b0;
      dbg_frame  <= 1'b0;
      dr_save    <= 1'b0;
      dr_restore <= 1'b0;
    end else begin
      stop_ack   <= 1'b0;
      smm_enter  <= 1'b0;
      dbg_frame  <= 1'b0;
      dr_save    <= 1'b0;
      dr_restore <= 1'b0;
      case (st)
        S_RUN, S_HALT: begin
          if (smi_now && !deliver) begin
            if (dbg_req && !io_now) begin
              dbg_frame <= 1'b1;
              smi_pend  <= 1'b1;
              pend_io   <= 1'b0;
            end else begin
              st        <= S_SMM;
              smm_enter <= 1'b1;
              dr_save   <= 1'b1;
              smi_pend  <= 1'b0;
              if (dbg_req) dbg_pend <= 1'b1;
            end
          end else begin
            if (deliver) begin
              dbg_frame <= 1'b1;
              dbg_pend  <= 1'b0;
              if (smi_req) begin
                smi_pend <= 1'b1;
                pend_io  <= smi_io;
              end
            end
            if (stop_req) begin
              st       <= S_STOP;
              ret_halt <= (st == S_HALT);
              stop_ack <= 1'b1;
            end else if (dbg_req) begin
              dbg_frame <= 1'b1;
            end else if (halt_stb && st == S_RUN) begin
              st <= S_HALT;
            end
          end
        end
        S_STOP: begin
          if (smi_req) begin
            smi_pend <= 1'b1;
            pend_io  <= smi_io;
          end
          if (!stop_req) st <= ret_halt ? S_HALT : S_RUN;
        end
        default: begin
          if (rsm_stb) begin
            st         <= S_RUN;
            dr_restore <= 1'b1;
            if (io_restart) dbg_pend <= 1'b0;
          end
        end
      endcase
    end
  end

  p_ack_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    stop_ack |=> !stop_ack);
  p_ack_on_entry_r2: assert property (@(posedge clk) disable iff (!rst_n)
    stop_ack |-> (st == S_STOP) && ($past(st) != S_STOP));
  p_halt_honours_stop_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_HALT && stop_req && !smi_now) |=> st == S_STOP);
  p_entry_saves_r5: assert property (@(posedge clk) disable iff (!rst_n)
    smm_enter |-> dr_save && (st == S_SMM) && ($past(st) != S_SMM));
  p_restore_on_exit_r6: assert property (@(posedge clk) disable iff (!rst_n)
    dr_restore |-> (st == S_RUN) && ($past(st) == S_SMM));
  p_no_frame_in_smm_r7: assert property (@(posedge clk) disable iff (!rst_n)
    dbg_frame |-> st != S_SMM);
  p_cancel_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_SMM && rsm_stb && io_restart) |=> !dbg_pend);
  p_smi_waits_in_stop_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_STOP && stop_req) |=> st == S_STOP);

endmodule

// File: tb/test_smm_stopclk_seq.sv
module test_smm_stopclk_seq;
  logic clk = 1'b0;
  logic rst_n, stop_req, smi_req, smi_io, dbg_req, halt_stb, rsm_stb, io_restart;
  logic [1:0] state_o;
  logic stop_ack, smm_enter, dbg_frame, dr_save, dr_restore;
  int n_run = 0;
  int n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  smm_stopclk_seq i_smm_stopclk_seq (
    .clk(clk), .rst_n(rst_n), .stop_req(stop_req), .smi_req(smi_req),
    .smi_io(smi_io), .dbg_req(dbg_req), .halt_stb(halt_stb), .rsm_stb(rsm_stb),
    .io_restart(io_restart), .state_o(state_o), .stop_ack(stop_ack),
    .smm_enter(smm_enter), .dbg_frame(dbg_frame), .dr_save(dr_save),
    .dr_restore(dr_restore)
  );

  task automatic check(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic clear_in();
    stop_req = 0; smi_req = 0; smi_io = 0; dbg_req = 0;
    halt_stb = 0; rsm_stb = 0; io_restart = 0;
  endtask

  task automatic step();
    @(posedge clk);
    #2;
  endtask

  task automatic do_reset();
    clear_in();
    rst_n = 0;
    step();
    step();
    rst_n = 1;
  endtask

  task automatic t_reset();
    do_reset();
    check("R1 state", state_o, 0);
    check("R1 strobes", {stop_ack, smm_enter, dbg_frame, dr_save, dr_restore}, 0);
  endtask

  task automatic t_stop_run();
    do_reset();
    stop_req = 1; step();
    check("R2 state", state_o, 2);
    check("R2 ack", stop_ack, 1);
    step();
    check("R2 ack one cycle", stop_ack, 0);
    stop_req = 0; step();
    check("R3 back to run", state_o, 0);
    stop_req = 1; step();
    check("R4 reenter", state_o, 2);
    check("R4 ack again", stop_ack, 1);
    stop_req = 0; step();
  endtask

  task automatic t_halt_stop();
    do_reset();
    halt_stb = 1; step(); halt_stb = 0;
    check("R12 halt", state_o, 1);
    stop_req = 1; step();
    check("R3 halt to stop", state_o, 2);
    check("R3 ack", stop_ack, 1);
    stop_req = 0; step();
    check("R3 back to halt", state_o, 1);
  endtask

  task automatic t_smi();
    do_reset();
    smi_req = 1; step(); smi_req = 0;
    check("R5 state", state_o, 3);
    check("R5 enter+save", {smm_enter, dr_save}, 3);
    step();
    check("R5 one cycle", {smm_enter, dr_save}, 0);
    rsm_stb = 1; step(); rsm_stb = 0;
    check("R6 state", state_o, 0);
    check("R6 restore", dr_restore, 1);
    step();
    rsm_stb = 1; step(); rsm_stb = 0;
    check("R6 ignored state", state_o, 0);
    check("R6 ignored restore", dr_restore, 0);
  endtask

  task automatic t_defer(input bit restart);
    do_reset();
    smi_req = 1; smi_io = 1; dbg_req = 1; step(); clear_in();
    check(restart ? "R8 smm" : "R7 smm", state_o, 3);
    check("R7 no frame at entry", dbg_frame, 0);
    step();
    rsm_stb = 1; io_restart = restart; step(); clear_in();
    check("R7 run after rsm", state_o, 0);
    check("R7 no frame at rsm", dbg_frame, 0);
    step();
    if (restart) check("R8 cancelled", dbg_frame, 0);
    else         check("R7 delivered", dbg_frame, 1);
    step();
    check(restart ? "R8 none later" : "R7 single pulse", dbg_frame, 0);
  endtask

  task automatic t_nonio();
    do_reset();
    smi_req = 1; smi_io = 0; dbg_req = 1; step(); clear_in();
    check("R9 frame first", dbg_frame, 1);
    check("R9 still run", state_o, 0);
    step();
    check("R9 smm next", state_o, 3);
    check("R9 enter", smm_enter, 1);
    rsm_stb = 1; step(); clear_in();
    step();
    check("R9 no frame after rsm", dbg_frame, 0);
  endtask

  task automatic t_dbg();
    do_reset();
    dbg_req = 1; step(); dbg_req = 0;
    check("R10 frame", dbg_frame, 1);
    check("R10 state", state_o, 0);
    step();
    check("R10 pulse", dbg_frame, 0);
    stop_req = 1; step();
    dbg_req = 1; step(); dbg_req = 0;
    check("R10 ignored in stop", dbg_frame, 0);
    stop_req = 0; step();
  endtask

  task automatic t_stop_smi();
    do_reset();
    stop_req = 1; step();
    smi_req = 1; step(); smi_req = 0;
    check("R11 stays stop", state_o, 2);
    stop_req = 0; step();
    check("R11 leaves stop", state_o, 0);
    step();
    check("R11 smm taken", state_o, 3);
    check("R11 enter", smm_enter, 1);
  endtask

  initial begin
    clear_in();
    rst_n = 0;
    t_reset();
    t_stop_run();
    t_halt_stop();
    t_smi();
    t_defer(0);
    t_defer(1);
    t_nonio();
    t_dbg();
    t_stop_smi();
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      done = 1;
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule